// File: doc/BRIEF.md
# Half-Word Flash Program Sequencer

This block sits between a memory-mapped request channel and a small flash array. Stores into the flash window turn into program operations, but only when three things hold: the store is half-word sized, the program-enable bit in the control register is set, and no earlier operation is still running. A program operation lasts a fixed number of clock cycles. While it runs, a busy flag shows in the status register and on a status pin. When it finishes, an end-of-operation flag is set. Software clears that flag by writing 1 to it.

Requests arrive over a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The block pulls `req_ready` low only for accesses to the flash window while an operation runs, so the requester stalls and must hold the request stable. Register accesses are never stalled, which lets software poll busy. Each accepted request gets exactly one response beat in the following cycle. The response path has no back-pressure. Control writes count only while the external lock input is low. Holding the lock input high clears program-enable.

Address bit `ADDR_W-1` picks the window: 0 selects the flash array and 1 selects the registers. In the flash window, bits `ADDR_W-2:1` index a half-word. Bit 1 also picks the data lane of the 32-bit bus.

Top module: `hw_flash_prog_seq`

## Requirements
- R1: After reset, busy, end-of-operation and program-enable read 0, and every array half-word reads 0xFFFF.
- R2: An accepted half-word write (size code 1) to the flash window with program-enable set raises `busy_o` in the next cycle. `busy_o` then stays high for exactly `PROG_CYCLES` cycles.
- R3: A write to the flash window with any size code other than 1 (0 byte, 2 word, 3 reserved) gets a response with `rsp_err` = 1. It leaves the array unchanged and starts no operation.
- R4: A half-word write to the flash window while program-enable is 0 is ignored without error. The array stays unchanged and busy stays 0.
- R5: The control register is at offset 0x000 of the register window. Bit 0 is program-enable and bit 1 reads back the lock input. A write sets bit 0 only while `lock_i` is 0, and `lock_i` = 1 clears program-enable in the next cycle.
- R6: While busy is 1, `req_ready` is 0 for every flash-window request and 1 for every register-window request.
- R7: A flash-window read returns the stored half-word in both 16-bit lanes of `rsp_rdata`. The half-word stored by a program is the lane picked by address bit 1 (1 = bits 31:16). It becomes visible once busy clears.
- R8: The status register is at offset 0x004 of the register window. Bit 0 is busy and bit 1 is end-of-operation. End-of-operation is set when a program completes. Writing 1 to bit 1 clears it, writing 0 has no effect, and a completion in the same cycle as a clear wins.
- R9: Every accepted request produces `rsp_valid` = 1 for exactly one cycle, in the cycle after acceptance. `rsp_err` is 1 only in the R3 case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Control register locked when high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address; MSB selects register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat, one cycle after acceptance |
| rsp_err | output | 1 | Bus error for wrong-size flash writes |
| rsp_rdata | output | 32 | Read data |
| busy_o | output | 1 | Program operation in progress |
| eop_o | output | 1 | End-of-operation flag |

## Verification
The assertions assume the requester obeys the channel rules. It holds the address, size and data stable while stalled, and it never starts a program unless program-enable was set in an earlier cycle. The bench drives one request at a time, changing inputs only on the falling edge, and holds each request until `req_ready` is seen high. Random stimulus varies size codes, lanes, indices, the enable bit and the lock input. Status checks wait for busy to clear, so end-of-operation predictions do not depend on when a completion lands.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned HW_W  = 16;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int unsigned CTRL_PE_BIT   = 0;
  localparam int unsigned CTRL_LOCK_BIT = 1;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_EOP_BIT  = 1;

  typedef struct packed {
    logic to_array;
    logic to_ctrl;
    logic to_stat;
    logic size_ok;
    logic hi_lane;
  } req_class_t;
endpackage

// File: rtl/fps_decode.sv
module fps_decode
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output req_class_t        cls_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-2:0] CTRL_OFS = '0;
  localparam logic [ADDR_W-2:0] STAT_OFS = (ADDR_W-1)'(4);

  always_comb begin
    cls_o.to_array = ~addr_i[ADDR_W-1];
    cls_o.to_ctrl  = addr_i[ADDR_W-1] & (addr_i[ADDR_W-2:0] == CTRL_OFS);
    cls_o.to_stat  = addr_i[ADDR_W-1] & (addr_i[ADDR_W-2:0] == STAT_OFS);
    cls_o.size_ok  = (size_i == SZ_HALF);
    cls_o.hi_lane  = addr_i[1];
    idx_o          = addr_i[ADDR_W-2:1];
  end
endmodule

// File: rtl/fps_regs.sv
module fps_regs
  import fps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_i,
  input  logic       wr_ctrl_i,
  input  logic       wr_stat_i,
  input  logic [1:0] wbits_i,
  input  logic       done_i,
  input  logic       busy_i,
  output logic       pe_o,
  output logic       eop_o,
  output logic [BUS_W-1:0] ctrl_rd_o,
  output logic [BUS_W-1:0] stat_rd_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_o  <= 1'b0;
      eop_o <= 1'b0;
    end else begin
      if (lock_i)         pe_o <= 1'b0;
      else if (wr_ctrl_i) pe_o <= wbits_i[CTRL_PE_BIT];

      if (done_i)                                eop_o <= 1'b1;
      else if (wr_stat_i && wbits_i[STAT_EOP_BIT]) eop_o <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_PE_BIT]   = pe_o;
    ctrl_rd_o[CTRL_LOCK_BIT] = lock_i;
    stat_rd_o = '0;
    stat_rd_o[STAT_BUSY_BIT] = busy_i;
    stat_rd_o[STAT_EOP_BIT]  = eop_o;
  end

  // R5
  lock_clears_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> !pe_o);
  // R8
  done_sets_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> eop_o);
  // R8
  busy_fall_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> eop_o);
endmodule

// File: rtl/fps_array.sv
module fps_array
  import fps_pkg::*;
#(
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned PROG_CYCLES = 6,
  localparam int unsigned DEPTH = 1 << IDX_W,
  localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic [HW_W-1:0]  start_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [HW_W-1:0]  rd_data_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [HW_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [HW_W-1:0]  data_q;

  assign busy_o    = (cnt_q != '0);
  assign done_o    = (cnt_q == CNT_W'(1));
  assign rd_data_o = mem[rd_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(PROG_CYCLES);
      idx_q  <= start_idx_i;
      data_q <= start_data_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done_o) begin
      mem[idx_q] <= data_q;
    end
  end

  // R6
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  // R2
  busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R2
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

// File: rtl/hw_flash_prog_seq.sv
module hw_flash_prog_seq
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned PROG_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              busy_o,
  output logic              eop_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  req_class_t       cls;
  logic [IDX_W-1:0] idx;
  logic             accept, start, bad_size, pe, done;
  logic [HW_W-1:0]  lane_data, arr_rd;
  logic [BUS_W-1:0] ctrl_rd, stat_rd, rd_mux;

  fps_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(req_addr), .size_i(req_size), .cls_o(cls), .idx_o(idx)
  );

  assign req_ready = !(cls.to_array && busy_o);
  assign accept    = req_valid && req_ready;
  assign lane_data = cls.hi_lane ? req_wdata[31:16] : req_wdata[15:0];
  assign start     = accept && req_write && cls.to_array && cls.size_ok && pe;
  assign bad_size  = accept && req_write && cls.to_array && !cls.size_ok;

  fps_array #(.IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_idx_i(idx),
    .start_data_i(lane_data), .rd_idx_i(idx), .rd_data_o(arr_rd),
    .busy_o(busy_o), .done_o(done)
  );

  fps_regs u_regs (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
    .wr_ctrl_i(accept && req_write && cls.to_ctrl),
    .wr_stat_i(accept && req_write && cls.to_stat),
    .wbits_i(req_wdata[1:0]), .done_i(done), .busy_i(busy_o),
    .pe_o(pe), .eop_o(eop_o), .ctrl_rd_o(ctrl_rd), .stat_rd_o(stat_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      if (cls.to_array)     rd_mux = {arr_rd, arr_rd};
      else if (cls.to_ctrl) rd_mux = ctrl_rd;
      else if (cls.to_stat) rd_mux = stat_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= bad_size;
      rsp_rdata <= accept ? rd_mux : '0;
    end
  end

  // R9
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R3
  err_only_bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> $past(req_write) && ($past(req_size) != SZ_HALF));
  // R4
  busy_needs_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(pe));
  // R9
  rsp_single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !$past(req_valid && req_ready) |-> 1'b0);
endmodule

// File: tb/tb_hw_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_hw_flash_prog_seq;
  localparam int ADDR_W = 10;
  localparam int PROG   = 6;
  localparam int DEPTH  = 1 << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] CTRL_A = 10'h200;
  localparam logic [ADDR_W-1:0] STAT_A = 10'h204;

  logic clk = 0, rst_n = 0, lock_i = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, busy_o, eop_o;
  logic [31:0] rsp_rdata;

  int nvec = 0, nfail = 0;
  bit done_flag = 0;
  logic [15:0] mdl [DEPTH];
  bit pe_m = 0, eop_m = 0;

  always #4 clk = ~clk;

  hw_flash_prog_seq #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) dut (.*);

  function automatic logic [ADDR_W-1:0] fa(input int idx);
    return {1'b0, idx[ADDR_W-3:0], 1'b0};
  endfunction
  function automatic logic [15:0] lane(input int idx, input logic [31:0] d);
    return idx[0] ? d[31:16] : d[15:0];
  endfunction
  function automatic logic [31:0] exp_stat(input bit b, input bit e);
    return {30'd0, e, b};
  endfunction
  function automatic logic [31:0] exp_ctrl(input bit l, input bit p);
    return {30'd0, l, p};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic xfer(input bit w, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                      input logic [31:0] d, output logic err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    err = rsp_err; rd = rsp_rdata;
    check("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic flash_wr(input int idx, input logic [1:0] sz, input logic [31:0] d);
    logic e; logic [31:0] r;
    xfer(1, sz, fa(idx), d, e, r);
    check(sz == 2'd1 ? "R4 no error on half write" : "R3 size error", {31'd0, e},
          {31'd0, sz != 2'd1});
    if (sz == 2'd1 && pe_m) begin mdl[idx] = lane(idx, d); eop_m = 1; end
  endtask

  task automatic flash_rd(input int idx, input string req);
    logic e; logic [31:0] r;
    xfer(0, 2'd1, fa(idx), 0, e, r);
    check(req, r, {mdl[idx], mdl[idx]});
  endtask

  task automatic ctrl_wr(input bit p);
    logic e; logic [31:0] r;
    xfer(1, 2'd2, CTRL_A, {31'd0, p}, e, r);
    if (!lock_i) pe_m = p;
  endtask

  task automatic reg_rd(input logic [ADDR_W-1:0] a, output logic [31:0] r);
    logic e;
    xfer(0, 2'd2, a, 0, e, r);
  endtask

  // R2: busy duration monitor
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) run++;
      else if (run != 0) begin
        check("R2 busy length", run, PROG);
        run = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic e;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 0);
    check("R1 eop", {31'd0, eop_o}, 0);
    reg_rd(CTRL_A, r); check("R1 ctrl", r, exp_ctrl(0, 0));
    flash_rd(0, "R1 erased");

    // R5 locked write ignored
    lock_i = 1;
    ctrl_wr(1);
    reg_rd(CTRL_A, r); check("R5 locked ctrl", r, exp_ctrl(1, 0));
    @(negedge clk) lock_i = 0;

    // R4 pe clear: ignored
    flash_wr(5, 2'd1, 32'hAAAA_5555);
    @(negedge clk); check("R4 no busy", {31'd0, busy_o}, 0);
    flash_rd(5, "R4 array unchanged");

    ctrl_wr(1);
    reg_rd(CTRL_A, r); check("R5 pe set", r, exp_ctrl(0, 1));

    // R3 bad sizes
    flash_wr(5, 2'd0, 32'h1111_2222);
    flash_wr(5, 2'd2, 32'h3333_4444);
    flash_wr(5, 2'd3, 32'h5555_6666);
    @(negedge clk); check("R3 no busy", {31'd0, busy_o}, 0);
    flash_rd(5, "R3 array unchanged");

    // R2/R6/R7 program with stall
    flash_wr(5, 2'd1, 32'h1234_5678);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2'd1; req_addr = fa(5);
    #1 check("R6 flash stalled while busy", {31'd0, req_ready}, 0);
    req_addr = STAT_A;
    #1 check("R6 regs ready while busy", {31'd0, req_ready}, 1);
    req_valid = 0;
    reg_rd(STAT_A, r); check("R6 status busy read", r, exp_stat(1, 0));
    flash_rd(5, "R7 read-back after stall");
    reg_rd(STAT_A, r); check("R8 eop set", r, exp_stat(0, 1));
    check("R8 eop pin", {31'd0, eop_o}, 1);

    // R8 clear semantics
    xfer(1, 2'd2, STAT_A, 32'h0, e, r);
    reg_rd(STAT_A, r); check("R8 write 0 keeps eop", r, exp_stat(0, 1));
    xfer(1, 2'd2, STAT_A, 32'h2, e, r);
    eop_m = 0;
    reg_rd(STAT_A, r); check("R8 write 1 clears eop", r, exp_stat(0, 0));

    // R7 boundary indices, both lanes
    flash_wr(DEPTH-1, 2'd1, 32'hBEEF_0000);
    flash_rd(DEPTH-1, "R7 top index hi lane");
    flash_wr(0, 2'd1, 32'h0000_C0DE);
    flash_rd(0, "R7 index 0 lo lane");

    // R5 lock clears pe
    @(negedge clk) lock_i = 1;
    @(negedge clk) lock_i = 0; pe_m = 0;
    reg_rd(CTRL_A, r); check("R5 lock clears pe", r, exp_ctrl(0, 0));

    // random phase
    void'($urandom(32'h5EED_0001));
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      logic [1:0] sz;
      op  = $urandom % 10;
      idx = $urandom % DEPTH;
      case (op)
        0: begin
          @(negedge clk);
          lock_i = (($urandom % 4) == 0);
          if (lock_i) pe_m = 0;
          ctrl_wr(($urandom % 4) != 0);
          reg_rd(CTRL_A, r); check("R5 random ctrl", r, exp_ctrl(lock_i, pe_m));
        end
        1, 2, 3, 4: begin
          sz = (($urandom % 3) == 0) ? 2'($urandom % 4) : 2'd1;
          flash_wr(idx, sz, $urandom);
        end
        5, 6, 7: flash_rd(idx, "R7 random read");
        default: begin
          wait_idle();
          reg_rd(STAT_A, r); check("R8 random status", r, exp_stat(0, eop_m));
          if ($urandom % 2) begin
            xfer(1, 2'd2, STAT_A, 32'h2, e, r);
            eop_m = 0;
          end
        end
      endcase
    end
    lock_i = 0;
    wait_idle();
    finish_run();
  end
endmodule